// File: doc/BRIEF.md
# Shared Cache Maintenance Command Front-End

This block is the register-facing front end of a shared last-level cache's maintenance logic. Software reaches it through a small register bus that supports 32-bit and 64-bit accesses. It can read a fixed geometry word, post set/way maintenance requests through a 64-bit command register, and poll a status word that gives the number of requests not yet carried out. The cache arrays themselves are not part of this block.

Each accepted request goes into a bounded first-in first-out queue. A stub engine drains the queue at a fixed rate, one entry every `DRAIN` cycles. For each entry it emits a one-cycle operation strobe that carries the opcode and the line selector. A request is committed only when the upper half of the command word is written. A bus limited to 32 bits can therefore stage the low half first and then trigger the request with the high half. Software uses the pending count for flow control, and it waits for the count to read zero to learn that all maintenance has finished.

Top module: `llc_maint_frontend`

## Requirements
- R1: A read at offset 0x000 returns the geometry word: bank count in bits [7:0], ways per bank in bits [15:8], log2 of sets per bank in bits [23:16], zero above. The values come from parameters, and writes to this offset leave it unchanged.
- R2: A 64-bit write (`bus_wide`=1) to offset 0x280 enqueues the whole 64-bit data word as one request.
- R3: A 32-bit write to 0x280 only stages bits [31:0] and enqueues nothing. A 32-bit write to 0x284 enqueues {written data[31:0], staged word}. Reset clears the staged word to zero.
- R4: Every dequeued request produces exactly one cycle of `op_valid`, with `op_code` = request bits [63:56] and `op_line` = request bits [55:6]. Requests come out in the order they were accepted.
- R5: While the queue is non-empty the engine dequeues one entry every `DRAIN` cycles, so two strobes are never closer than `DRAIN` cycles. The first strobe after the queue leaves empty follows `DRAIN` cycles after it.
- R6: A read at 0x288 returns the pending request count in its low bits. The count is incremented by each accepted request, decremented by each dequeue, and reads zero once the queue has drained.
- R7: A request that arrives while `QDEPTH` requests are pending is dropped and sets a sticky overflow flag in status bit 31. Writing 1 to status bit 31 clears the flag and leaves the count unchanged.
- R8: Unmapped offsets, and the command register itself, read as zero. Writes to unmapped offsets have no effect on the count or on the operations emitted.
- R9: Reset empties the queue, clears the overflow flag and holds `op_valid` low. Requests queued before reset are never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data (32-bit accesses use bits [31:0]) |
| bus_rdata | output | 64 | Read data, combinational for the current read |
| op_valid | output | 1 | One-cycle maintenance operation strobe |
| op_code | output | 8 | Opcode of the emitted operation |
| op_line | output | 50 | Line selector of the emitted operation |

## Verification
The embedded assertions check properties that must hold in every cycle: the pending count never exceeds the queue depth, a commit to a full queue always leaves the overflow flag set, and a low-half write never raises the count. They also check that strobes never fire on an empty queue and, with a multi-cycle drain period, never fire on adjacent cycles. Other behaviours can only be shown by the bench scenarios. These are the exact payload and first-in first-out order of emitted operations, the exact `DRAIN`-cycle spacing under backlog, the status count after each write of a 16-command burst, the values of the geometry word, and the loss of queued work and of the staged word across reset.

// File: rtl/llc_maint_frontend.sv
module llc_maint_frontend #(
  parameter int ADDR_W    = 12,
  parameter int BANKS     = 16,
  parameter int WAYS      = 16,
  parameter int SETS_LOG2 = 10,
  parameter int QDEPTH    = 255,
  parameter int DRAIN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              op_valid,
  output logic [7:0]        op_code,
  output logic [49:0]       op_line
);
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int DIV_W = (DRAIN > 1) ? $clog2(DRAIN) : 1;
  localparam int ENT_W = 58;
  localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_CLO  = ADDR_W'(12'h280);
  localparam logic [ADDR_W-1:0] OFF_CHI  = ADDR_W'(12'h284);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12'h288);
  localparam logic [23:0] GEOM = {8'(SETS_LOG2), 8'(WAYS), 8'(BANKS)};

  logic [ENT_W-1:0] mem [QDEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic [DIV_W-1:0] div;
  logic [31:0]      staged;
  logic             ovf;

  wire wr     = bus_valid & bus_write;
  wire rd     = bus_valid & ~bus_write;
  wire commit = wr & ((bus_wide & (bus_addr == OFF_CLO)) | (~bus_wide & (bus_addr == OFF_CHI)));
  wire stage  = wr & ~bus_wide & (bus_addr == OFF_CLO);
  wire full   = (count == CNT_W'(QDEPTH));
  wire push   = commit & ~full;
  wire pop    = (count != '0) & (div == DIV_W'(DRAIN - 1));
  wire [63:0] cmd_word = bus_wide ? bus_wdata : {bus_wdata[31:0], staged};
  wire [31:0] status   = {ovf, {(31 - CNT_W){1'b0}}, count};

  always_comb begin
    bus_rdata = '0;
    if (rd && bus_addr == OFF_CFG)  bus_rdata = {40'b0, GEOM};
    if (rd && bus_addr == OFF_STAT) bus_rdata = {32'b0, status};
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= {cmd_word[63:56], cmd_word[55:6]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      div      <= '0;
      staged   <= '0;
      ovf      <= 1'b0;
      op_valid <= 1'b0;
      op_code  <= '0;
      op_line  <= '0;
    end else begin
      if (stage) staged <= bus_wdata[31:0];
      if (commit && full) ovf <= 1'b1;
      else if (wr && bus_addr == OFF_STAT && bus_wdata[31]) ovf <= 1'b0;
      if (push) wptr <= (wptr == PTR_W'(QDEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(QDEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (count == '0 || pop) div <= '0;
      else                    div <= div + 1'b1;
      op_valid <= pop;
      if (pop) {op_code, op_line} <= mem[rptr];
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(QDEPTH)); // R6
  AST_FULL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full) |=> ovf); // R7
  AST_LOW_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    stage |=> count <= $past(count)); // R3
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> !op_valid); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!op_valid && count == '0)); // R9
  generate
    if (DRAIN > 1) begin : g_spacing
      AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid); // R5
    end
  endgenerate
endmodule

// File: tb/llc_maint_frontend_test.sv
module llc_maint_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 20;
  localparam int DR = 64;
  localparam logic [63:0] GEOM_EXP = 64'h0000_0000_0005_0804;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, bus_wide = 0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic op_valid;
  logic [7:0] op_code;
  logic [49:0] op_line;

  llc_maint_frontend #(.ADDR_W(12), .BANKS(4), .WAYS(8), .SETS_LOG2(5), .QDEPTH(QD), .DRAIN(DR)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .op_valid(op_valid), .op_code(op_code), .op_line(op_line));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  exp_code [256];
  logic [49:0] exp_line [256];
  logic [7:0]  got_code [256];
  logic [49:0] got_line [256];
  int          got_cyc  [256];
  int exp_n = 0, got_n = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) if (op_valid && got_n < 256) begin
    got_code[got_n] = op_code; got_line[got_n] = op_line; got_cyc[got_n] = cyc; got_n++;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic wide, logic [11:0] a, logic [63:0] d);
    bus_valid = 1; bus_write = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic wide, logic [11:0] a, output logic [63:0] d);
    bus_valid = 1; bus_write = 0; bus_wide = wide; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic expect_cmd(logic [63:0] w);
    exp_code[exp_n] = w[63:56]; exp_line[exp_n] = w[55:6]; exp_n++;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(0, 12'h288, s);
      if (s[4:0] == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_ops(string req, int from, bit spacing);
    chk({req, " op count"}, 64'(got_n), 64'(exp_n));
    for (int i = from; i < exp_n && i < got_n; i++) begin
      chk({req, " op_code order"}, 64'(got_code[i]), 64'(exp_code[i]));
      chk({req, " op_line order"}, 64'(got_line[i]), 64'(exp_line[i]));
      if (spacing && i > from) chk("R5 strobe spacing", 64'(got_cyc[i] - got_cyc[i-1]), 64'(DR));
    end
  endtask

  initial begin
    logic [63:0] r, w;
    int base, t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 / R1 reset state
    chk("R9 op_valid after reset", 64'(op_valid), 0);
    rd(0, 12'h288, r); chk("R9 status after reset", r, 0);
    rd(0, 12'h000, r); chk("R1 geometry 32-bit", r, GEOM_EXP);
    rd(1, 12'h000, r); chk("R1 geometry 64-bit", r, GEOM_EXP);
    wr(1, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, 12'h000, r); chk("R1 geometry after write", r, GEOM_EXP);
    // R8 unmapped and command reads
    wr(1, 12'h100, 64'h0700_0000_0000_0040);
    rd(0, 12'h100, r); chk("R8 unmapped read", r, 0);
    rd(1, 12'h280, r); chk("R8 command reads zero", r, 0);
    rd(0, 12'h288, r); chk("R8 unmapped write no enqueue", r, 0);
    repeat (DR + 4) @(negedge clk);
    chk("R8 unmapped write no op", 64'(got_n), 0);

    // R3 high write after reset uses zero staged low word
    wr(0, 12'h284, 64'h0000_0000_0712_3456);
    expect_cmd(64'h0712_3456_0000_0000);
    rd(0, 12'h288, r); chk("R3 high commits", r, 1);
    wr(0, 12'h280, 64'h0000_0000_89AB_CDC0);
    rd(0, 12'h288, r); chk("R3 low stages only", r, 1);
    wr(0, 12'h284, 64'h0000_0000_0300_00A5);
    expect_cmd(64'h0300_00A5_89AB_CDC0);
    rd(0, 12'h288, r); chk("R3 staged pair commits", r, 2);
    wait_idle();
    cmp_ops("R3 R4", 0, 1'b0);

    // R2 R6 burst of 16 set/way commands, status after each
    base = exp_n;
    w = 64'h0700_0000_0000_0000;
    for (int i = 0; i < 16; i++) begin
      wr(1, 12'h280, w + (64'(i) << 6));
      expect_cmd(w + (64'(i) << 6));
      rd(0, 12'h288, r); chk("R6 status during burst", r, 64'(i + 1));
    end
    wait_idle();
    rd(0, 12'h288, r); chk("R6 status zero after drain", r, 0);
    cmp_ops("R2 R4 burst", base, 1'b1);

    // R5 first strobe DRAIN cycles after queue leaves empty
    t0 = cyc;
    base = exp_n;
    wr(1, 12'h280, 64'h0AFF_FFFF_FFFF_FFC0);
    expect_cmd(64'h0AFF_FFFF_FFFF_FFC0);
    wait_idle();
    cmp_ops("R5 single", base, 1'b0);
    if (got_n > base) chk("R5 first strobe latency", 64'(got_cyc[base] - t0), 64'(DR + 1));

    // R7 overflow
    base = exp_n;
    for (int i = 0; i < QD + 2; i++) begin
      wr(1, 12'h280, 64'h0500_0000_0000_0000 + (64'(i) << 6));
      if (i < QD) expect_cmd(64'h0500_0000_0000_0000 + (64'(i) << 6));
    end
    rd(0, 12'h288, r); chk("R7 full with flag", r, 64'h8000_0000 | 64'(QD));
    wr(0, 12'h288, 64'h0);
    rd(0, 12'h288, r); chk("R7 write 0 keeps flag", r, 64'h8000_0000 | 64'(QD));
    wr(0, 12'h288, 64'h8000_0000);
    rd(0, 12'h288, r); chk("R7 write 1 clears flag", r, 64'(QD));
    wait_idle();
    cmp_ops("R7 dropped not emitted", base, 1'b1);

    // R9 reset mid-queue discards entries and staged word
    wr(0, 12'h280, 64'h0000_0000_FFFF_FFC0);
    for (int i = 0; i < 3; i++) wr(1, 12'h280, 64'h0600_0000_0000_1000);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(0, 12'h288, r); chk("R9 queue emptied", r, 0);
    repeat (3 * DR) @(negedge clk);
    chk("R9 no stale ops", 64'(got_n), 64'(exp_n));
    wr(0, 12'h284, 64'h0000_0000_0700_0001);
    expect_cmd(64'h0700_0001_0000_0000);
    wait_idle();
    cmp_ops("R9 R3 staged cleared", exp_n - 1, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule